// File: doc/BRIEF.md
# Master clock select and divide

This block produces the processor clock and the master clock of a chip from four free-running input clocks: a slow clock, a main clock, a PLL clock and a USB PLL clock. A glitch-free multiplexer picks one source. A power-of-two prescaler then divides it, and its output is the processor clock. A small ratio divider after the prescaler makes the master clock, so the processor can run faster than the master clock.

Software sets the source, prescale and ratio through a small synchronous register interface. Every accepted configuration write drops a ready bit. The bit comes back only after the new source is running and the new master clock has completed its settling cycles. A rising ready bit can raise an interrupt. A single write that tries to change both the source and the ratio is refused.

Top module: `mclk_ctrl`

## Requirements
- R1: Source code 0 selects the slow clock, 1 the main clock, 2 the PLL clock and 3 the USB PLL clock. With prescale code 0 the processor clock has the period of the selected source.
- R2: Prescale code p (0 to 6) makes the processor clock period 2^p times the selected source period.
- R3: The master clock period is the processor clock period times 1, 2, 4 or 3 for ratio codes 0, 1, 2 and 3.
- R4: At most one source is gated through at any time. During a source change no processor clock pulse is shorter than half the period of the faster of the two clocks involved.
- R5: An accepted configuration write clears ready (status bit 0) on the register clock edge that takes the write. Ready sets again only once the new source is gated through and the master clock has run its settling cycles.
- R6: The edge on which ready sets also sets the interrupt flag (status bit 1). The irq output is the flag ANDed with the enable bit (address 2, bit 0). Writing 1 to status bit 1 clears the flag.
- R7: A configuration write whose source and ratio fields both differ from the current values is ignored. It sets the error flag (status bit 2, cleared by writing 1), and it leaves ready and both clocks unchanged.
- R8: The configuration sits at address 0: source in bits [1:0], prescale in bits [6:4], ratio in bits [9:8]. Status is at address 1 and the interrupt enable at address 2. After reset the configuration reads 0x001 (main clock, divide by 1, ratio 1), status reads 0x1 and enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every source |
| src_clk | input | 4 | Source clocks: [0] slow, [1] main, [2] PLL, [3] USB PLL |
| wr_en | input | 1 | Write strobe, sampled on rising clk |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cpu_clk | output | 1 | Processor clock (prescaler output) |
| mst_clk | output | 1 | Master clock (ratio divider output) |
| irq | output | 1 | Interrupt request |

## Verification
The ready drop is due on the register clock edge that takes the write, so the bench samples status at the falling edge right after that edge. Its return arrives after an unknown number of source and master clock cycles, so the bench polls status at falling edges and sets a long bound. The interrupt and flag bits are read after ready is back. Clock periods are measured only after ready has returned and one further master edge has passed, which keeps any settling edge out of the measurement. Error-flag and readback effects of an ignored write are read one register cycle after the write. The pulse-width monitor runs only during source-only changes.

// File: rtl/mclk_pkg.sv
// Shared widths, register layout and types of the master clock block.
package mclk_pkg;
    localparam int NSRC   = 4;
    localparam int SEL_W  = 2;
    localparam int PRES_W = 3;
    localparam int DIV_W  = 2;

    // register addresses
    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;

    // field positions in the configuration register
    localparam int SEL_LSB  = 0;
    localparam int PRES_LSB = 4;
    localparam int DIV_LSB  = 8;

    // status bit positions
    localparam int ST_READY = 0;
    localparam int ST_IRQ   = 1;
    localparam int ST_ERR   = 2;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [PRES_W-1:0] pres;
        logic [SEL_W-1:0]  sel;
    } mclk_cfg_t;

    typedef enum logic [1:0] {
        RS_READY,
        RS_DRAIN,
        RS_SWITCH,
        RS_ARM
    } rdy_state_t;
endpackage

// File: rtl/mclk_src_mux.sv
// Glitch-free N-way clock selector.
// Each source owns an enable shift register that is clocked on that
// source's falling edge. A source asks to be enabled only when it is
// selected and every other enable is off, so the old clock is turned off
// before the new one is turned on, each of them while it is low.
// Assumes all sources toggle while the select changes and during reset.
module mclk_src_mux
    import mclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RESET_SRC   = 1
) (
    input  logic [NSRC-1:0]  src_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic [NSRC-1:0]  en,
    output logic             sel_clk
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic                   want;
        logic [SYNC_STAGES-1:0] sh;

        assign want = (sel == SEL_W'(i)) && ((en & ~(NSRC'(1) << i)) == '0);

        // purpose: move the enable request into this source's domain on its low phase
        always_ff @(negedge src_clk[i]) begin
            if (!rst_n) sh <= {SYNC_STAGES{i == RESET_SRC}};
            else        sh <= {sh[SYNC_STAGES-2:0], want};
        end

        assign en[i] = sh[SYNC_STAGES-1];
    end

    assign sel_clk = |(src_clk & en);
endmodule

// File: rtl/mclk_prescale.sv
// Power-of-two prescaler. A ripple-free binary counter runs on the
// selected clock, and the output taps either the input (code 0) or
// counter bit code-1. Codes above MAX_LOG2 clamp to the largest ratio.
// Assumes the code changes only while software waits for ready.
module mclk_prescale
    import mclk_pkg::*;
#(
    parameter int MAX_LOG2 = 6
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [PRES_W-1:0] pres,
    output logic              clk_out
);
    localparam int IDX_W = $clog2(MAX_LOG2 + 1);

    logic [MAX_LOG2-1:0] cnt;
    logic [MAX_LOG2:0]   taps;
    logic [IDX_W-1:0]    idx;

    // purpose: free-running divide chain on the selected clock
    always_ff @(posedge clk_in) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // purpose: clamp the code to the implemented tap range
    always_comb begin
        if (pres > PRES_W'(MAX_LOG2)) idx = IDX_W'(MAX_LOG2);
        else                          idx = IDX_W'(pres);
    end

    assign taps    = {cnt, clk_in};
    assign clk_out = taps[idx];
endmodule

// File: rtl/mclk_ratio_div.sv
// Ratio divider from processor clock to master clock (x1, x2, x4, x3),
// plus the settle counter that runs on the master clock. Once the arm
// request has been synchronised, ack rises after SETTLE_CYCLES master
// cycles. Ack falls again once arm is seen low.
// Assumes arm is a register output of the register-clock domain.
module mclk_ratio_div
    import mclk_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 2
) (
    input  logic             cpu_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             arm,
    output logic             mst_clk,
    output logic             ack
);
    localparam int SC_W = $clog2(SETTLE_CYCLES + 1);

    logic [1:0]             lim, half, cnt, nxt;
    logic                   q;
    logic [SYNC_STAGES-1:0] arm_sh;
    logic [SC_W-1:0]        settle;

    // purpose: decode the ratio code into a wrap value and a high-phase length
    always_comb begin
        unique case (div)
            2'd0:    begin lim = 2'd0; half = 2'd0; end
            2'd1:    begin lim = 2'd1; half = 2'd1; end
            2'd2:    begin lim = 2'd3; half = 2'd2; end
            default: begin lim = 2'd2; half = 2'd1; end
        endcase
        nxt = (cnt >= lim) ? 2'd0 : cnt + 2'd1;
    end

    // purpose: modulo counter with a registered, glitch-free output phase
    always_ff @(posedge cpu_clk) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 1'b0;
        end else begin
            cnt <= nxt;
            q   <= (nxt < half);
        end
    end

    assign mst_clk = (div == 2'd0) ? cpu_clk : q;

    // purpose: synchronise arm and count settling cycles of the master clock
    always_ff @(posedge mst_clk) begin
        if (!rst_n) begin
            arm_sh <= '0;
            settle <= '0;
            ack    <= 1'b0;
        end else begin
            arm_sh <= {arm_sh[SYNC_STAGES-2:0], arm};
            if (!arm_sh[SYNC_STAGES-1]) begin
                settle <= '0;
                ack    <= 1'b0;
            end else begin
                if (settle < SC_W'(SETTLE_CYCLES)) settle <= settle + 1'b1;
                ack <= (settle == SC_W'(SETTLE_CYCLES));
            end
        end
    end
endmodule

// File: rtl/mclk_regs.sv
// Register file and ready sequencer in the register-clock domain.
// A legal configuration write restarts the sequence. DRAIN waits for a
// stale ack to fall, SWITCH waits for the synchronised enables to match
// the new source, ARM waits for the master-clock settle ack, then READY.
// Assumes en and ack are asynchronous and syncs them here.
module mclk_regs
    import mclk_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_SRC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   en,
    input  logic              ack,
    output mclk_cfg_t         cfg_q,
    output logic              arm,
    output logic              ready,
    output logic              irq_en,
    output logic              err_flag,
    output logic              irq
);
    localparam logic [NSRC-1:0] RST_ONEHOT = NSRC'(1) << RESET_SRC;

    logic [NSRC-1:0]        en_pipe [SYNC_STAGES];
    logic [SYNC_STAGES-1:0] ack_sh;
    logic                   ack_s, cfg_wr, stat_wr, bad_wr, take_wr, irq_flag;
    mclk_cfg_t              new_cfg;
    rdy_state_t             st;
    logic                   unused_wdata;

    assign unused_wdata = ^wr_data;
    assign ack_s   = ack_sh[SYNC_STAGES-1];
    assign new_cfg = '{div:  wr_data[DIV_LSB +: DIV_W],
                       pres: wr_data[PRES_LSB +: PRES_W],
                       sel:  wr_data[SEL_LSB +: SEL_W]};
    assign cfg_wr  = wr_en && (wr_addr == ADDR_W'(A_CFG));
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(A_STAT));
    assign bad_wr  = cfg_wr && (new_cfg.sel != cfg_q.sel) && (new_cfg.div != cfg_q.div);
    assign take_wr = cfg_wr && !bad_wr;

    // purpose: bring the source enables and settle ack into this domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) en_pipe[k] <= RST_ONEHOT;
            ack_sh <= '0;
        end else begin
            en_pipe[0] <= en;
            for (int k = 1; k < SYNC_STAGES; k++) en_pipe[k] <= en_pipe[k-1];
            ack_sh <= {ack_sh[SYNC_STAGES-2:0], ack};
        end
    end

    // purpose: configuration register and ready sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{div: '0, pres: '0, sel: SEL_W'(RESET_SRC)};
            st    <= RS_READY;
        end else if (take_wr) begin
            cfg_q <= new_cfg;
            st    <= RS_DRAIN;
        end else begin
            unique case (st)
                RS_DRAIN:  if (!ack_s) st <= RS_SWITCH;
                RS_SWITCH: if (en_pipe[SYNC_STAGES-1] == (NSRC'(1) << cfg_q.sel)) st <= RS_ARM;
                RS_ARM:    if (ack_s) st <= RS_READY;
                default:   st <= RS_READY;
            endcase
        end
    end

    // purpose: registered arm request toward the master-clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= 1'b0;
        else        arm <= (st == RS_ARM) && !take_wr;
    end

    // purpose: sticky interrupt and error flags, enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            err_flag <= 1'b0;
            irq_en   <= 1'b0;
        end else begin
            if ((st == RS_ARM) && ack_s && !take_wr)   irq_flag <= 1'b1;
            else if (stat_wr && wr_data[ST_IRQ])       irq_flag <= 1'b0;
            if (bad_wr)                                err_flag <= 1'b1;
            else if (stat_wr && wr_data[ST_ERR])       err_flag <= 1'b0;
            if (wr_en && (wr_addr == ADDR_W'(A_IEN)))  irq_en   <= wr_data[0];
        end
    end

    assign ready = (st == RS_READY);
    assign irq   = irq_flag && irq_en;

    // purpose: read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CFG)) begin
            rd_data[SEL_LSB +: SEL_W]   = cfg_q.sel;
            rd_data[PRES_LSB +: PRES_W] = cfg_q.pres;
            rd_data[DIV_LSB +: DIV_W]   = cfg_q.div;
        end else if (rd_addr == ADDR_W'(A_STAT)) begin
            rd_data[ST_READY] = ready;
            rd_data[ST_IRQ]   = irq_flag;
            rd_data[ST_ERR]   = err_flag;
        end else if (rd_addr == ADDR_W'(A_IEN)) begin
            rd_data[0] = irq_en;
        end
    end
endmodule

// File: rtl/mclk_ctrl.sv
// Master clock controller top: source mux, prescaler (processor clock),
// ratio divider (master clock) and register interface.
// Assumes rst_n is held long enough for every source to see it.
module mclk_ctrl
    import mclk_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 2,
    parameter int MAX_LOG2      = 6,
    parameter int RESET_SRC     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cpu_clk,
    output logic              mst_clk,
    output logic              irq
);
    mclk_cfg_t       cfg_q;
    logic [NSRC-1:0] src_en;
    logic            sel_clk, arm, ack, ready, irq_en, err_flag;

    mclk_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .SYNC_STAGES(SYNC_STAGES), .RESET_SRC(RESET_SRC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .en(src_en), .ack(ack), .cfg_q(cfg_q), .arm(arm), .ready(ready),
        .irq_en(irq_en), .err_flag(err_flag), .irq(irq)
    );

    mclk_src_mux #(.SYNC_STAGES(SYNC_STAGES), .RESET_SRC(RESET_SRC)) u_mux (
        .src_clk(src_clk), .rst_n(rst_n), .sel(cfg_q.sel),
        .en(src_en), .sel_clk(sel_clk)
    );

    mclk_prescale #(.MAX_LOG2(MAX_LOG2)) u_pres (
        .clk_in(sel_clk), .rst_n(rst_n), .pres(cfg_q.pres), .clk_out(cpu_clk)
    );

    mclk_ratio_div #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_div (
        .cpu_clk(cpu_clk), .rst_n(rst_n), .div(cfg_q.div), .arm(arm),
        .mst_clk(mst_clk), .ack(ack)
    );
endmodule

// File: rtl/mclk_ctrl_chk.sv
// Protocol checker for mclk_ctrl, attached by bind. Observes the
// register-clock domain only.
module mclk_ctrl_chk
    import mclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input mclk_cfg_t         cfg,
    input logic              ready,
    input logic              irq,
    input logic              irq_en,
    input logic              err_flag,
    input logic [NSRC-1:0]   src_en
);
    logic both_change, cfg_access, unused_wd;

    assign unused_wd   = ^wr_data;
    assign cfg_access  = wr_en && (wr_addr == ADDR_W'(A_CFG));
    assign both_change = (wr_data[SEL_LSB +: SEL_W] != cfg.sel) &&
                         (wr_data[DIV_LSB +: DIV_W] != cfg.div);

    p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_en));

    p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_access && !both_change) |=> !ready);

    p_ready_on_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (src_en == (NSRC'(1) << cfg.sel)));

    p_irq_on_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && irq_en) |-> irq);

    p_refused_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_access && both_change) |=> ($stable(cfg) && err_flag && $stable(ready)));
endmodule

bind mclk_ctrl mclk_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg_q), .ready(ready), .irq(irq),
    .irq_en(irq_en), .err_flag(err_flag), .src_en(src_en)
);

// File: tb/mclk_ctrl_tb.sv
`timescale 1ns/1ps
module mclk_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_clk = 4'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cpu_clk, mst_clk, irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] st_after_wr;
    logic [1:0]  cur_sel = 2'd1;
    logic [2:0]  cur_pres = 3'd0;
    logic [1:0]  cur_div = 2'd0;
    logic        mon_on = 1'b0;
    logic        mon_seen = 1'b0;
    realtime     last_edge = 0.0;
    realtime     min_pulse = 1.0e9;

    localparam realtime SP0 = 100.0, SP1 = 40.0, SP2 = 6.0, SP3 = 8.0;

    mclk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cpu_clk(cpu_clk), .mst_clk(mst_clk), .irq(irq)
    );

    always #5 clk = ~clk;
    always #(SP0/2) src_clk[0] = ~src_clk[0];
    always #(SP1/2) src_clk[1] = ~src_clk[1];
    always #(SP2/2) src_clk[2] = ~src_clk[2];
    always #(SP3/2) src_clk[3] = ~src_clk[3];

    // pulse-width monitor for source changes (R4)
    always @(cpu_clk) begin
        if (mon_on && mon_seen && ($realtime - last_edge) < min_pulse)
            min_pulse = $realtime - last_edge;
        last_edge = $realtime;
        mon_seen  = mon_on;
    end

    function automatic realtime src_period(input logic [1:0] s);
        case (s)
            2'd0:    return SP0;
            2'd1:    return SP1;
            2'd2:    return SP2;
            default: return SP3;
        endcase
    endfunction

    function automatic realtime exp_cpu(input logic [1:0] s, input logic [2:0] p);
        return src_period(s) * (1 << p);
    endfunction

    function automatic realtime exp_mst(input logic [1:0] s, input logic [2:0] p, input logic [1:0] d);
        int f;
        case (d)
            2'd0: f = 1;
            2'd1: f = 2;
            2'd2: f = 4;
            default: f = 3;
        endcase
        return exp_cpu(s, p) * f;
    endfunction

    function automatic logic [31:0] cfg_word(input logic [1:0] s, input logic [2:0] p, input logic [1:0] d);
        return {22'd0, d, 1'b0, p, 2'b00, s};
    endfunction

    task automatic chk(input logic ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_t(input string req, input string what, input realtime act, input realtime exp);
        checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f ns expected %0.3f ns", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = 2'd1;
        #2 st_after_wr = rd_data;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #2 d = rd_data;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int n = 0; n < 40000; n++) begin
            rd(2'd1, s);
            if (s[0]) return;
        end
        chk(1'b0, "R5", "ready never returned", 32'h0, 32'h1);
    endtask

    task automatic measure(output realtime pc, output realtime pm);
        realtime t0;
        @(posedge mst_clk);
        @(posedge mst_clk); t0 = $realtime;
        @(posedge mst_clk); pm = $realtime - t0;
        @(posedge cpu_clk); t0 = $realtime;
        @(posedge cpu_clk); pc = $realtime - t0;
    endtask

    // one legal configuration change with full checking
    task automatic apply(input logic [1:0] s, input logic [2:0] p, input logic [1:0] d);
        logic [31:0] v;
        realtime pc, pm;
        wr(2'd0, cfg_word(s, p, d));
        chk(st_after_wr[0] == 1'b0, "R5", "ready low after write", st_after_wr, 32'h0);
        wait_ready();
        rd(2'd1, v);
        chk(v[1] == 1'b1 && irq == 1'b1, "R6", "irq flag after ready", {v[30:0], irq}, 32'h3);
        wr(2'd1, 32'h2);
        chk(irq == 1'b0 && st_after_wr[1] == 1'b0, "R6", "irq cleared by w1c", {st_after_wr[30:0], irq}, 32'h0);
        rd(2'd0, v);
        chk(v == cfg_word(s, p, d), "R8", "config readback", v, cfg_word(s, p, d));
        cur_sel = s; cur_pres = p; cur_div = d;
        measure(pc, pm);
        chk_t(p == 0 ? "R1" : "R2", "processor clock period", pc, exp_cpu(s, p));
        chk_t("R3", "master clock period", pm, exp_mst(s, p, d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        realtime pc, pm;
        void'($urandom(32'h5A17));
        repeat (30) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8 reset state
        rd(2'd0, v); chk(v == 32'h1, "R8", "reset config", v, 32'h1);
        rd(2'd1, v); chk(v == 32'h1, "R8", "reset status", v, 32'h1);
        rd(2'd2, v); chk(v == 32'h0, "R8", "reset enable", v, 32'h0);
        chk(irq == 1'b0, "R6", "irq idle after reset", {31'd0, irq}, 32'h0);
        measure(pc, pm);
        chk_t("R1", "reset processor clock = main", pc, SP1);
        chk_t("R3", "reset master clock ratio 1", pm, SP1);

        wr(2'd2, 32'h1);
        rd(2'd2, v); chk(v == 32'h1, "R6", "enable set", v, 32'h1);

        // ratio 3 on main
        apply(2'd1, 3'd0, 2'd3);

        // refused write: source and ratio both change
        wr(2'd0, cfg_word(2'd2, 3'd0, 2'd0));
        chk(st_after_wr[2:0] == 3'b101, "R7", "error set, ready kept", st_after_wr, 32'h5);
        rd(2'd0, v); chk(v == cfg_word(2'd1, 3'd0, 2'd3), "R7", "config unchanged", v, cfg_word(2'd1, 3'd0, 2'd3));
        measure(pc, pm);
        chk_t("R7", "master clock unchanged", pm, exp_mst(2'd1, 3'd0, 2'd3));
        chk(irq == 1'b0, "R7", "no interrupt from refused write", {31'd0, irq}, 32'h0);
        wr(2'd1, 32'h4);
        chk(st_after_wr[2] == 1'b0, "R7", "error cleared by w1c", st_after_wr, 32'h1);

        // largest prescale
        apply(2'd1, 3'd6, 2'd3);
        // back-to-back writes while not ready
        wr(2'd0, cfg_word(2'd3, 3'd6, 2'd3));
        apply(2'd3, 3'd0, 2'd3);
        // fast-to-fast source change watched by the pulse monitor
        mon_on = 1'b1;
        apply(2'd2, 3'd0, 2'd3);
        mon_on = 1'b0;

        // constrained random changes
        for (int it = 0; it < 16; it++) begin
            logic [1:0] ns, nd;
            logic [2:0] np;
            ns = cur_sel; nd = cur_div; np = cur_pres;
            if ($urandom % 2 == 0) begin
                do ns = 2'($urandom % 4); while (ns == cur_sel || (ns == 2'd0 && cur_pres > 3'd3));
                mon_on = 1'b1;
            end else begin
                do nd = 2'($urandom % 4); while (nd == cur_div);
                np = (cur_sel == 2'd0) ? 3'($urandom % 4) : 3'($urandom % 7);
            end
            apply(ns, np, nd);
            mon_on = 1'b0;
        end

        chk(min_pulse >= 3.0 - 0.001, "R4", "shortest pulse during source change (ps)",
            32'($rtoi(min_pulse * 1000.0)), 32'd3000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule